// File: doc/BRIEF.md
# Synchronisable Third-Order Sinc Decimator

This block turns the one-bit stream of a second-order sigma-delta modulator into signed 16-bit words. Each accepted bit passes through three cascaded accumulators. At every decimation point, the running sum is differenced three times at the decimated rate. The result is a third-order sinc response, whose first notch falls at the output word rate. A sample strobe marks each modulator bit. In the system that strobe runs at the master clock divided by 128, but the block only treats it as a clock enable. A three-bit rate code picks one of four decimation ratios, and so sets the word rate and the notch positions without changing the shape of the response.

A restart clears every accumulator, difference stage and counter. There are three ways to start one: reset, holding the synchronisation input high, or changing the effective rate code. After a restart, the block withholds its data-ready pulse and keeps its settled flag low until the filter's window holds nothing but post-restart samples. That happens at the end of the third complete output period. From then on, each new word comes with a single-cycle data-ready pulse.

Top module: `sinc3_decim`

## Requirements
- R1: A stream of all ones settles to 16'h7FFF and a stream of all zeros settles to 16'h8000. The output word is two's complement, with bit value 1 meaning positive full scale.
- R2: An alternating stream (one on even sample indices, zero on odd ones) settles to exactly 16'h0000.
- R3: The rate code is {CLK, FS1, FS0} on bits [2:0]. The ratio is 80 for CLK=0,FS0=0; 96 for CLK=0,FS0=1; 384 for CLK=1,FS0=0; and 320 for CLK=1,FS0=1. FS1 (bit 1) has no effect: changing only FS1 neither restarts the filter nor alters word timing or value.
- R4: Let g = R^3 and M = ceil(2^42 / g), and let s be the settled filter sum (g times the fraction of ones in a pattern whose period divides R). The output word is min(floor(s*M / 2^26), 65535), taken over 16 bits with bit 15 inverted. A pattern with one one in four gives 16'hC000; a pattern with three ones in four gives 16'h4000.
- R5: While the sync input is high, data_valid and data_ready stay low.
- R6: After a restart, the first data-ready pulse comes two clock cycles after the rising edge that accepts the 3R-th sample strobe. No word from the first two periods is flagged.
- R7: data_ready is a one-cycle pulse. Once settled, successive pulses are exactly R accepted strobes apart.
- R8: data_valid stays low from a restart until the first settled word. It then stays high until the next restart.
- R9: A change of the effective rate code (bits 2 and 0) clears the filter exactly as a sync pulse does. data_valid is low in the cycle after the changed code is sampled.
- R10: No sample is taken in a cycle with the sample strobe low, so word spacing in clock cycles scales with the strobe interval.
- R11: After reset, data_out is 0 and data_ready and data_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Modulator sample strobe (clock enable) |
| bit_in | input | 1 | Modulator output bit |
| sync_in | input | 1 | Holds the filter cleared while high |
| rate_sel | input | 3 | Rate code {CLK, FS1, FS0} |
| data_out | output | 16 | Filtered word, two's complement |
| data_rdy | output | 1 | One-cycle pulse with each settled word |
| data_valid | output | 1 | High once the filter has settled since the last restart |

## Verification
The bench sweeps every ratio against five bit densities. A wrong scaling constant or truncation shows up as an off-by-one word at midscale or at a quarter of full scale, and missing saturation wraps full scale to 16'h8000. It times the first pulse after both sync and rate-change restarts. A design that counts two periods, or that counts cycles instead of strobes, flags a partial-window word or drifts under a strobe every other cycle. It also flips FS1 on a settled stream: a design that decodes the full code restarts and drops data_valid.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  localparam int unsigned ORDER  = 3;
  localparam int unsigned OUT_W  = 16;

  // ratio for each {CLK, FS0} pair
  localparam int unsigned R_C0F0 = 80;
  localparam int unsigned R_C0F1 = 96;
  localparam int unsigned R_C1F0 = 384;
  localparam int unsigned R_C1F1 = 320;
  localparam int unsigned R_MAX  = 384;
  localparam int unsigned R_MIN  = 80;

  localparam int unsigned CNT_W  = $clog2(R_MAX);
  localparam int unsigned ACC_W  = ORDER * CNT_W + 1;
  localparam int unsigned SCL_SH = ACC_W - 2;
  localparam int unsigned RCP_SH = OUT_W + SCL_SH;
  localparam int unsigned RCP_W  = RCP_SH + 1 - ORDER * ($clog2(R_MIN + 1) - 1);
  localparam int unsigned PER_W  = $clog2(ORDER + 1);

  function automatic logic [63:0] gain_of(input int unsigned r);
    logic [63:0] g;
    g = 64'd1;
    for (int i = 0; i < ORDER; i++) g = g * 64'(r);
    return g;
  endfunction

  function automatic logic [63:0] recip_of(input int unsigned r);
    logic [63:0] g;
    g = gain_of(r);
    return ((64'd1 << RCP_SH) + g - 64'd1) / g;
  endfunction

endpackage

// File: rtl/sinc3_rate.sv
module sinc3_rate
  import sinc3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rate_sel,
  input  logic             sync_in,
  output logic             clr,
  output logic [CNT_W-1:0] ratio_m1,
  output logic [RCP_W-1:0] recip,
  output logic [ACC_W-1:0] gain
);

  localparam logic [RCP_W-1:0] RCP_00 = RCP_W'(recip_of(R_C0F0));
  localparam logic [RCP_W-1:0] RCP_01 = RCP_W'(recip_of(R_C0F1));
  localparam logic [RCP_W-1:0] RCP_10 = RCP_W'(recip_of(R_C1F0));
  localparam logic [RCP_W-1:0] RCP_11 = RCP_W'(recip_of(R_C1F1));
  localparam logic [ACC_W-1:0] GN_00  = ACC_W'(gain_of(R_C0F0));
  localparam logic [ACC_W-1:0] GN_01  = ACC_W'(gain_of(R_C0F1));
  localparam logic [ACC_W-1:0] GN_10  = ACC_W'(gain_of(R_C1F0));
  localparam logic [ACC_W-1:0] GN_11  = ACC_W'(gain_of(R_C1F1));

  logic [1:0] key;
  logic [1:0] key_q;
  logic [1:0] key_d;
  logic       fs1_unused;

  // FS1 plays no part in the ratio
  assign key        = {rate_sel[2], rate_sel[0]};
  assign fs1_unused = rate_sel[1];
  assign clr        = sync_in | (key != key_q);

  always_comb key_d = key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= 2'b00;
    else        key_q <= key_d;
  end

  always_comb begin
    unique case (key_q)
      2'b00: begin ratio_m1 = CNT_W'(R_C0F0 - 1); recip = RCP_00; gain = GN_00; end
      2'b01: begin ratio_m1 = CNT_W'(R_C0F1 - 1); recip = RCP_01; gain = GN_01; end
      2'b10: begin ratio_m1 = CNT_W'(R_C1F0 - 1); recip = RCP_10; gain = GN_10; end
      default: begin ratio_m1 = CNT_W'(R_C1F1 - 1); recip = RCP_11; gain = GN_11; end
    endcase
  end

endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int unsigned NSTG = ORDER
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_en,
  input  logic [CNT_W-1:0] ratio_m1,
  output logic             dec_pend,
  output logic             dec_ok
);

  localparam int unsigned PW = $clog2(NSTG + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]    per_q, per_d;
  logic             pend_q, pend_d;
  logic             ok_q, ok_d;

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    pend_d = 1'b0;
    ok_d   = 1'b0;
    if (clr) begin
      cnt_d = '0;
      per_d = '0;
    end else if (smp_en) begin
      if (cnt_q == ratio_m1) begin
        cnt_d  = '0;
        pend_d = 1'b1;
        ok_d   = (per_q >= PW'(NSTG - 1));
        if (per_q < PW'(NSTG)) per_d = per_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      pend_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      pend_q <= pend_d;
      ok_q   <= ok_d;
    end
  end

  assign dec_pend = pend_q;
  assign dec_ok   = ok_q;

  // sample counter stays inside the selected period
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_m1);

  // decimation marker never lasts two cycles
  assert_pend_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ
  import sinc3_pkg::*;
#(
  parameter int unsigned NSTG = ORDER,
  parameter int unsigned AW   = ACC_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp_en,
  input  logic          bit_in,
  output logic [AW-1:0] acc_out
);

  logic [NSTG:0][AW-1:0] tap;

  assign tap[0] = {{(AW-1){1'b0}}, bit_in};

  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_acc
      logic [AW-1:0] q, d;
      always_comb begin
        d = q;
        if (clr)         d = '0;
        else if (smp_en) d = q + tap[s];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign tap[s+1] = q;
    end
  endgenerate

  assign acc_out = tap[NSTG];

  // first accumulator advances by exactly the accepted bit
  assert_first_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !clr) |=> ((tap[1] - $past(tap[1])) == AW'($past(bit_in))));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
  import sinc3_pkg::*;
#(
  parameter int unsigned NSTG = ORDER,
  parameter int unsigned AW   = ACC_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          dec_pend,
  input  logic          dec_ok,
  input  logic [AW-1:0] acc_in,
  output logic [AW-1:0] cmb_q,
  output logic          cmb_vld
);

  logic [NSTG:0][AW-1:0] tap;
  logic [AW-1:0]         res_q, res_d;
  logic                  vld_q, vld_d;

  assign tap[0] = acc_in;

  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_dif
      logic [AW-1:0] dly_q, dly_d;
      always_comb begin
        dly_d = dly_q;
        if (clr)           dly_d = '0;
        else if (dec_pend) dly_d = tap[s];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
      end
      assign tap[s+1] = tap[s] - dly_q;
    end
  endgenerate

  always_comb begin
    res_d = res_q;
    vld_d = 1'b0;
    if (clr) begin
      res_d = '0;
    end else if (dec_pend) begin
      res_d = tap[NSTG];
      vld_d = dec_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign cmb_q   = res_q;
  assign cmb_vld = vld_q;

endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale
  import sinc3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cmb_vld,
  input  logic [ACC_W-1:0] cmb_q,
  input  logic [RCP_W-1:0] recip,
  output logic [OUT_W-1:0] data_out,
  output logic             data_rdy,
  output logic             data_valid
);

  localparam int unsigned PRD_W = ACC_W + RCP_W;

  logic [PRD_W-1:0] prod;
  logic             over;
  logic [OUT_W-1:0] ulev;
  logic [OUT_W-1:0] word;
  logic [OUT_W-1:0] dat_q, dat_d;
  logic             rdy_q, rdy_d;
  logic             vld_q, vld_d;

  assign prod = PRD_W'(cmb_q) * PRD_W'(recip);
  assign over = |prod[PRD_W-1:SCL_SH+OUT_W];
  assign ulev = over ? {OUT_W{1'b1}} : prod[SCL_SH+OUT_W-1:SCL_SH];
  assign word = {~ulev[OUT_W-1], ulev[OUT_W-2:0]};

  always_comb begin
    dat_d = dat_q;
    rdy_d = 1'b0;
    vld_d = vld_q;
    if (clr) begin
      vld_d = 1'b0;
    end else if (cmb_vld) begin
      dat_d = word;
      rdy_d = 1'b1;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      rdy_q <= rdy_d;
      vld_q <= vld_d;
    end
  end

  assign data_out   = dat_q;
  assign data_rdy   = rdy_q;
  assign data_valid = vld_q;

  assert_rdy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q);

  assert_rdy_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> vld_q);

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             bit_in,
  input  logic             sync_in,
  input  logic [2:0]       rate_sel,
  output logic [OUT_W-1:0] data_out,
  output logic             data_rdy,
  output logic             data_valid
);

  logic             clr;
  logic [CNT_W-1:0] ratio_m1;
  logic [RCP_W-1:0] recip;
  logic [ACC_W-1:0] gain;
  logic             dec_pend;
  logic             dec_ok;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] cmb_q;
  logic             cmb_vld;

  sinc3_rate u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .sync_in  (sync_in),
    .clr      (clr),
    .ratio_m1 (ratio_m1),
    .recip    (recip),
    .gain     (gain)
  );

  sinc3_ctrl #(.NSTG(ORDER)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .smp_en   (smp_en),
    .ratio_m1 (ratio_m1),
    .dec_pend (dec_pend),
    .dec_ok   (dec_ok)
  );

  sinc3_integ #(.NSTG(ORDER), .AW(ACC_W)) u_integ (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .smp_en  (smp_en),
    .bit_in  (bit_in),
    .acc_out (acc_sum)
  );

  sinc3_comb #(.NSTG(ORDER), .AW(ACC_W)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .dec_pend (dec_pend),
    .dec_ok   (dec_ok),
    .acc_in   (acc_sum),
    .cmb_q    (cmb_q),
    .cmb_vld  (cmb_vld)
  );

  sinc3_scale u_scale (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .cmb_vld    (cmb_vld),
    .cmb_q      (cmb_q),
    .recip      (recip),
    .data_out   (data_out),
    .data_rdy   (data_rdy),
    .data_valid (data_valid)
  );

  // a settled sum never exceeds the full-scale gain
  assert_sum_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmb_vld |-> (cmb_q <= gain));

  assert_sync_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (!data_valid && !data_rdy));

  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !clr) |=> data_valid);

  assert_code_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ({rate_sel[2], rate_sel[0]} != $past({rate_sel[2], rate_sel[0]})) |=> !data_valid);

endmodule

// File: tb/sinc3_decim_tb.sv
`timescale 1ns/1ps
module sinc3_decim_tb;

  logic        clk;
  logic        rst_n;
  logic        smp_en;
  logic        bit_in;
  logic        sync_in;
  logic [2:0]  rate_sel;
  logic [15:0] data_out;
  logic        data_rdy;
  logic        data_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  sinc3_decim u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .bit_in     (bit_in),
    .sync_in    (sync_in),
    .rate_sel   (rate_sel),
    .data_out   (data_out),
    .data_rdy   (data_rdy),
    .data_valid (data_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R3 ratio map: {bit2, bit0} selects, bit1 ignored
  function automatic int ratio_for(input logic [2:0] code);
    case ({code[2], code[0]})
      2'b00:   return 80;
      2'b01:   return 96;
      2'b10:   return 384;
      default: return 320;
    endcase
  endfunction

  // patterns: 0 ones, 1 zeros, 2 alternating, 3 one-in-four, 4 three-in-four
  function automatic logic pat_bit(input int pat, input int idx);
    case (pat)
      0:       return 1'b1;
      1:       return 1'b0;
      2:       return (idx % 2) == 0;
      3:       return (idx % 4) == 0;
      default: return (idx % 4) != 0;
    endcase
  endfunction

  // R4 word formula
  function automatic longint exp_word(input int r, input int pat);
    longint g, num, s, m, u;
    g = longint'(r) * r * r;
    case (pat)
      0: num = 4; 1: num = 0; 2: num = 2; 3: num = 1; default: num = 3;
    endcase
    s = g * num / 4;
    m = ((longint'(1) << 42) + g - 1) / g;
    u = (s * m) >>> 26;
    if (u > 65535) u = 65535;
    return u ^ 32'h8000;
  endfunction

  function automatic string req_for(input int pat);
    if (pat <= 1) return "R1";
    if (pat == 2) return "R2";
    return "R4";
  endfunction

  task automatic run_case(input logic [2:0] code, input int pat, input int stride,
                          input bit via_sync, input int words);
    int r, acc_n, edges, e3, last, seen, limit;
    bit early_bad;
    longint ew;
    r = ratio_for(code);
    ew = exp_word(r, pat);
    @(negedge clk);
    if (via_sync) begin
      sync_in  = 1'b1;
      smp_en   = 1'b1;
      rate_sel = code;
      repeat (4) @(negedge clk);
      check(!data_valid && !data_rdy, "R5", "flags during sync",
            {data_valid, data_rdy}, 0);
      sync_in = 1'b0;
    end else begin
      rate_sel = code;
      smp_en   = 1'b0;
      @(negedge clk);
      check(!data_valid, "R9", "valid after code change", data_valid, 0);
    end
    acc_n = 0; edges = 0; e3 = -1; last = 0; seen = 0; early_bad = 1'b0;
    limit = (3 * r + 4 + words * r) * stride + 20;
    for (int c = 0; c < limit && seen < words; c++) begin
      smp_en = (c % stride) == 0;
      bit_in = pat_bit(pat, acc_n);
      @(posedge clk);
      edges++;
      if (smp_en) begin
        acc_n++;
        if (acc_n == 3 * r) e3 = edges;
      end
      @(negedge clk);
      if (data_rdy) begin
        seen++;
        check(longint'(data_out) == ew, req_for(pat), "settled word",
              longint'(data_out), ew);
        check(data_valid, "R8", "valid with word", data_valid, 1);
        if (seen == 1)
          check(e3 > 0 && edges - e3 == 2, "R6", "first word delay",
                edges - e3, 2);
        else
          check(edges - last == r * stride, (stride > 1) ? "R10" : "R7",
                "word spacing", edges - last, r * stride);
        last = edges;
      end else if (seen == 0 && data_valid) begin
        early_bad = 1'b1;
      end
    end
    check(seen == words, "R7", "word count", seen, words);
    check(!early_bad, "R8", "valid before settle", early_bad, 0);
  endtask

  // R3: flip only FS1 on a settled all-ones stream at ratio 320
  task automatic fs1_flip();
    int n;
    bit dropped;
    n = 0; dropped = 1'b0;
    rate_sel = 3'b111;
    smp_en   = 1'b1;
    bit_in   = 1'b1;
    while (n < 400) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!data_valid) dropped = 1'b1;
      if (data_rdy) break;
    end
    check(!dropped, "R3", "valid kept over FS1 flip", dropped, 0);
    check(n == 320, "R3", "spacing after FS1 flip", n, 320);
    check(data_out == 16'h7FFF, "R3", "word after FS1 flip", data_out, 16'h7FFF);
  endtask

  initial begin
    logic [2:0] codes [4];
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b100; codes[3] = 3'b101;
    rst_n = 1'b0; smp_en = 1'b0; bit_in = 1'b0; sync_in = 1'b0; rate_sel = 3'b000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_out == 16'h0000, "R11", "reset data", data_out, 0);
    check(!data_rdy && !data_valid, "R11", "reset flags", {data_rdy, data_valid}, 0);

    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 5; p++)
        run_case(codes[k], p, 1, 1'b1, 2);

    run_case(3'b101, 0, 1, 1'b1, 2);
    fs1_flip();
    run_case(3'b001, 2, 1, 1'b0, 2);
    run_case(3'b111, 3, 2, 1'b1, 2);
    run_case(3'b100, 4, 1, 1'b0, 2);
    run_case(3'b010, 1, 3, 1'b1, 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule